// File: doc/BRIEF.md
# Segment Address Translator with Protection

This block converts a segment value and a 16-bit offset into a 24-bit physical address. It has two modes. After reset it runs in real mode. There the segment value is shifted left by four bits and added to the offset. The result is a 20-bit address, and the four upper address lines stay at zero.

A one-way switch moves the block into protected mode, and only a reset brings it back. In protected mode the segment value is a selector. The selector picks one entry of a small descriptor cache, which software fills through a load port. Each entry holds a base, a limit, a type, a privilege level, a present flag and an accessed flag. The physical address is the base plus the offset. Before it is released, the access is checked for presence, privilege and limit.

Every request gets its answer one clock later. The answer carries the address, a fault code, the type of the selected entry and that entry's accessed flag as it stood before the request.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset the block is in real mode (`pm_active`=0), `rsp_valid` is 0, and every cache entry is not present, with its accessed flag clear.
- R2: In real mode the address is ({seg,4'h0} + offset) modulo 2^20, and bits 23..20 are 0. The fault code is 0 and the descriptor contents have no effect.
- R3: A cycle with `pm_enter` high switches the block to protected mode from the next cycle on. It stays there until reset, and a further `pm_enter` has no effect.
- R4: In protected mode the cache index is selector bits [3 +: log2(entries)]. All other selector bits are ignored.
- R5: In protected mode a request that passes all checks returns (base + offset) modulo 2^24 with fault code 0. The response also carries the type of the selected entry.
- R6: An offset greater than the limit gives fault code 1 (limit). An offset equal to the limit is allowed.
- R7: An access to an entry whose present flag is 0 gives fault code 2 (not present).
- R8: An access whose current privilege is numerically greater than the entry's privilege gives fault code 3 (privilege). Level 0 is the most privileged.
- R9: When several checks fail at once, not present is reported first, then privilege, then limit.
- R10: A protected-mode access that passes all checks sets the accessed flag of its entry. A faulting access leaves the flag unchanged, and a load clears it. `rsp_accessed` reports the flag's value before the access.
- R11: A response with a nonzero fault code has address 0.
- R12: A request in cycle t gives `rsp_valid`=1 in cycle t+1. With no request, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pm_enter | input | 1 | Switch to protected mode |
| req_valid | input | 1 | Translation request |
| req_sel | input | 16 | Segment value or selector |
| req_off | input | 16 | Offset within the segment |
| req_cpl | input | 2 | Current privilege level of the requester |
| ld_en | input | 1 | Write one cache entry |
| ld_idx | input | 3 | Entry to write |
| ld_base | input | 24 | Segment base |
| ld_limit | input | 16 | Highest valid offset |
| ld_type | input | 4 | Segment type |
| ld_dpl | input | 2 | Segment privilege level |
| ld_present | input | 1 | Segment is resident |
| pm_active | output | 1 | Protected mode is on |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 24 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 not present, 3 privilege |
| rsp_type | output | 4 | Type of the selected entry (0 in real mode) |
| rsp_accessed | output | 1 | Accessed flag of the entry before this access |

## Verification
The bench builds the block with its default eight-entry cache. With that size the index field is three bits wide. The selector can then be given set upper bits and set low bits that must be ignored, while it still reaches entries at both ends of the cache. With the 24-bit base, a base near the top of the space can wrap around through the offset add. The 16-bit segment path lets the largest real-mode sum overflow past 20 bits.

// File: rtl/seg_xlate_pkg.sv
// Package: shared widths, descriptor record and fault codes for the
// segment translator. Assumes a 24-bit physical space and 16-bit offsets.
package seg_xlate_pkg;
    localparam int PA_W   = 24;
    localparam int SEL_W  = 16;
    localparam int OFF_W  = 16;
    localparam int LIM_W  = 16;
    localparam int TYPE_W = 4;
    localparam int PRIV_W = 2;
    localparam int REAL_W = SEL_W + 4;

    typedef struct packed {
        logic [PA_W-1:0]   base;
        logic [LIM_W-1:0]  limit;
        logic [TYPE_W-1:0] kind;
        logic [PRIV_W-1:0] dpl;
        logic              present;
    } seg_desc_t;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_LIMIT  = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_PRIV   = 2'd3
    } seg_fault_e;
endpackage

// File: rtl/seg_desc_cache.sv
// Module: descriptor cache. Holds N_ENT descriptors plus accessed flags.
// One asynchronous read port and one load port. A load has priority over
// an accessed-flag set to the same entry in the same cycle.
// Assumes: rst_n is synchronous and active low.
module seg_desc_cache
    import seg_xlate_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  seg_desc_t        ld_desc,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc,
    output logic             rd_acc
);
    seg_desc_t        ent_q [N_ENT];
    logic [N_ENT-1:0] acc_q;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        // Store one entry; reset leaves it absent and clean.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
                acc_q[g] <= 1'b0;
            end else if (ld_en && ld_idx == IDX_W'(g)) begin
                ent_q[g] <= ld_desc;
                acc_q[g] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                acc_q[g] <= 1'b1;
            end
        end
    end

    // Read the addressed entry.
    always_comb begin
        rd_desc = ent_q[rd_idx];
        rd_acc  = acc_q[rd_idx];
    end

    assert_load_clears_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !acc_q[$past(ld_idx)]);
    assert_set_marks_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(ld_en && ld_idx == set_idx)) |=> acc_q[$past(set_idx)]);
endmodule

// File: rtl/seg_prot_check.sv
// Module: protection checks for one protected-mode access. Purely
// combinational. Order of report: not present, privilege, limit.
// Assumes: a privilege value of 0 is the most privileged.
module seg_prot_check
    import seg_xlate_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PRIV_W-1:0] cpl,
    output seg_fault_e        fault
);
    logic over_limit;
    logic too_weak;

    // Evaluate each check and pick the highest-ranked failure.
    always_comb begin
        over_limit = offset > desc.limit;
        too_weak   = desc.dpl < cpl;
        if (!desc.present)   fault = FLT_ABSENT;
        else if (too_weak)   fault = FLT_PRIV;
        else if (over_limit) fault = FLT_LIMIT;
        else                 fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_addr_calc.sv
// Module: forms the physical address for either mode. Real mode wraps at
// 20 bits and keeps the upper lines low. A faulting protected access
// yields address 0. Purely combinational.
module seg_addr_calc
    import seg_xlate_pkg::*;
(
    input  logic              prot,
    input  logic [SEL_W-1:0]  seg,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PA_W-1:0]   base,
    input  seg_fault_e        fault,
    output logic [PA_W-1:0]   addr
);
    logic [REAL_W-1:0] real_sum;
    logic [PA_W-1:0]   prot_sum;

    // Compute both candidate addresses and select by mode.
    always_comb begin
        real_sum = {seg, 4'h0} + REAL_W'(offset);
        prot_sum = base + PA_W'(offset);
        if (!prot)                 addr = PA_W'(real_sum);
        else if (fault != FLT_NONE) addr = '0;
        else                       addr = prot_sum;
    end
endmodule

// File: rtl/seg_xlate_top.sv
// Module: segment translator top. Holds the sticky mode flag, the
// descriptor cache and the response registers; one cycle of latency.
// Assumes: synchronous active-low reset; the load port may be used in
// any mode.
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int IDX_LO = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pm_enter,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [PRIV_W-1:0] req_cpl,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [PA_W-1:0]   ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    input  logic [TYPE_W-1:0] ld_type,
    input  logic [PRIV_W-1:0] ld_dpl,
    input  logic              ld_present,
    output logic              pm_active,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [1:0]        rsp_fault,
    output logic [TYPE_W-1:0] rsp_type,
    output logic              rsp_accessed
);
    logic              pm_q;
    logic [IDX_W-1:0]  sel_idx;
    seg_desc_t         ld_desc;
    seg_desc_t         cur_desc;
    logic              cur_acc;
    seg_fault_e        chk_fault;
    seg_fault_e        use_fault;
    logic [PA_W-1:0]   calc_addr;
    logic              hit_ok;

    // Pick the index field out of the selector and pack the load record.
    always_comb begin
        sel_idx = req_sel[IDX_LO +: IDX_W];
        ld_desc = '{base: ld_base, limit: ld_limit, kind: ld_type,
                    dpl: ld_dpl, present: ld_present};
        use_fault = pm_q ? chk_fault : FLT_NONE;
        hit_ok    = req_valid && pm_q && (chk_fault == FLT_NONE);
    end

    // Sticky mode flag: only reset returns the block to real mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        pm_q <= 1'b0;
        else if (pm_enter) pm_q <= 1'b1;
    end

    seg_desc_cache #(.N_ENT(N_ENT)) i_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_desc (ld_desc),
        .set_en  (hit_ok),
        .set_idx (sel_idx),
        .rd_idx  (sel_idx),
        .rd_desc (cur_desc),
        .rd_acc  (cur_acc)
    );

    seg_prot_check i_check (
        .desc   (cur_desc),
        .offset (req_off),
        .cpl    (req_cpl),
        .fault  (chk_fault)
    );

    seg_addr_calc i_addr (
        .prot   (pm_q),
        .seg    (req_sel),
        .offset (req_off),
        .base   (cur_desc.base),
        .fault  (use_fault),
        .addr   (calc_addr)
    );

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_addr     <= '0;
            rsp_fault    <= FLT_NONE;
            rsp_type     <= '0;
            rsp_accessed <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr     <= calc_addr;
                rsp_fault    <= use_fault;
                rsp_type     <= pm_q ? cur_desc.kind : '0;
                rsp_accessed <= pm_q ? cur_acc : 1'b0;
            end
        end
    end

    assign pm_active = pm_q;

    assert_real_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !pm_active) |-> rsp_addr[PA_W-1:20] == '0);
    assert_real_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !pm_active) |-> rsp_fault == FLT_NONE);
    assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pm_active |=> pm_active);
    assert_fault_zero_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> rsp_addr == '0);
    assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/test_seg_xlate_top.sv
// Directed bench: one task per scenario, each checking its own results.
module test_seg_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pm_enter = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_cpl = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [23:0] ld_base = '0;
    logic [15:0] ld_limit = '0;
    logic [3:0]  ld_type = '0;
    logic [1:0]  ld_dpl = '0;
    logic        ld_present = 1'b0;
    logic        pm_active, rsp_valid, rsp_accessed;
    logic [23:0] rsp_addr;
    logic [1:0]  rsp_fault;
    logic [3:0]  rsp_type;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_xlate_top i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .pm_enter(pm_enter), .req_valid(req_valid),
        .req_sel(req_sel), .req_off(req_off), .req_cpl(req_cpl),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base), .ld_limit(ld_limit),
        .ld_type(ld_type), .ld_dpl(ld_dpl), .ld_present(ld_present),
        .pm_active(pm_active), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_type(rsp_type), .rsp_accessed(rsp_accessed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [23:0] base,
                        input logic [15:0] lim, input logic [3:0] ty,
                        input logic [1:0] dpl, input logic pres);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_base = base; ld_limit = lim;
        ld_type = ty; ld_dpl = dpl; ld_present = pres;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic access(input logic [15:0] sel, input logic [15:0] off,
                          input logic [1:0] cpl);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_off = off; req_cpl = cpl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 pm_active", pm_active, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        @(negedge clk);
        chk("R12 idle rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_real;
        access(16'h1234, 16'h0010, 2'd3);
        chk("R12 valid", rsp_valid, 1);
        chk("R2 addr", rsp_addr, 24'h012350);
        chk("R2 fault", rsp_fault, 0);
        access(16'hFFFF, 16'hFFFF, 2'd0);
        chk("R2 wrap", rsp_addr, 24'h00FFEF);
        load(3'd1, 24'hABC000, 16'h0000, 4'h5, 2'd0, 1'b1);
        access(16'h0008, 16'h0100, 2'd3);
        chk("R2 ignores desc addr", rsp_addr, 24'h000180);
        chk("R2 ignores desc fault", rsp_fault, 0);
        chk("R2 type zero", rsp_type, 0);
    endtask

    task automatic t_enter;
        @(negedge clk); pm_enter = 1'b1;
        @(negedge clk); pm_enter = 1'b0;
        chk("R3 enter", pm_active, 1);
        access(16'h0028, 16'h0000, 2'd0);
        chk("R1 empty entry absent", rsp_fault, 2);
        chk("R11 zero on fault", rsp_addr, 0);
    endtask

    task automatic t_prot;
        load(3'd1, 24'h123400, 16'h00FF, 4'hA, 2'd2, 1'b1);
        access(16'h0008, 16'h0010, 2'd2);
        chk("R5 addr", rsp_addr, 24'h123410);
        chk("R5 fault", rsp_fault, 0);
        chk("R5 type", rsp_type, 4'hA);
        chk("R10 first acc", rsp_accessed, 0);
        access(16'h0008, 16'h00FF, 2'd0);
        chk("R6 at limit ok", rsp_fault, 0);
        chk("R10 second acc", rsp_accessed, 1);
        access(16'h0008, 16'h0100, 2'd2);
        chk("R6 over limit", rsp_fault, 1);
        chk("R11 limit addr", rsp_addr, 0);
        access(16'h0008, 16'h0010, 2'd3);
        chk("R8 privilege", rsp_fault, 3);
        access(16'h800B, 16'h0001, 2'd1);
        chk("R4 upper bits ignored", rsp_addr, 24'h123401);
        load(3'd4, 24'hFFFFF0, 16'hFFFF, 4'h2, 2'd3, 1'b1);
        access(16'h0020, 16'h0020, 2'd3);
        chk("R5 base wrap", rsp_addr, 24'h000010);
        access(16'h0038, 16'h0000, 2'd0);
        chk("R4 top entry absent", rsp_fault, 2);
    endtask

    task automatic t_priority;
        load(3'd2, 24'h000100, 16'h0000, 4'h1, 2'd0, 1'b0);
        access(16'h0010, 16'h0005, 2'd3);
        chk("R9 absent first", rsp_fault, 2);
        chk("R7 absent", rsp_fault, 2);
        load(3'd3, 24'h000100, 16'h0000, 4'h1, 2'd0, 1'b1);
        access(16'h0018, 16'h0005, 2'd3);
        chk("R9 privilege before limit", rsp_fault, 3);
    endtask

    task automatic t_accessed;
        load(3'd6, 24'h040000, 16'h0000, 4'h3, 2'd3, 1'b1);
        access(16'h0030, 16'h0001, 2'd0);
        chk("R10 fault access", rsp_fault, 1);
        access(16'h0030, 16'h0000, 2'd0);
        chk("R10 fault left flag", rsp_accessed, 0);
        access(16'h0030, 16'h0000, 2'd0);
        chk("R10 set after ok", rsp_accessed, 1);
        load(3'd1, 24'h123400, 16'h00FF, 4'hA, 2'd2, 1'b1);
        access(16'h0008, 16'h0000, 2'd0);
        chk("R10 load clears", rsp_accessed, 0);
    endtask

    task automatic t_sticky;
        @(negedge clk); pm_enter = 1'b1;
        @(negedge clk); pm_enter = 1'b0;
        chk("R3 repeat enter", pm_active, 1);
        repeat (3) @(negedge clk);
        chk("R3 stays", pm_active, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset to real", pm_active, 0);
        access(16'h0008, 16'h0000, 2'd0);
        chk("R1 real after reset", rsp_addr, 24'h000080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_real();
        t_enter();
        t_prot();
        t_priority();
        t_accessed();
        t_sticky();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule